// File: doc/BRIEF.md
# Oscillator trim and divide controller

This block is the register-side controller of an on-chip RC oscillator. A single 32-bit control word sits behind a simple write port with byte strobes and a read port that always shows the current word. The word holds four things: a signed 6-bit trim code, a clock divide factor, a standby keep-alive bit and a read-only stable-clock flag. The block runs entirely on the oscillator clock, which is treated here as a free-running input.

While reset is held, the block captures a factory trim value from its input. From the end of reset, that captured value drives the oscillator's trim pins. The readable trim field shows zero during this time. It keeps showing zero until software writes the byte that holds the trim. From that write on, the software value both drives the pins and reads back. A write that leaves the trim byte strobe low cannot disturb the factory trim, so software can update the divide factor or the standby bit without recalibrating.

A divider turns the oscillator clock into a one-cycle enable pulse every N cycles, where N is 1 to 32. A new factor is adopted only at the end of the period in progress. A small timer raises the stable flag a fixed 16 clock cycles after the oscillator enable rises, and clears the flag in the same cycle that the enable falls.

Top module: `osc_trim_ctrl`

## Requirements
- R1: The trim field occupies bits [5:0] of the word as a two's complement code (-32 to +31). The output `trim_code` always carries the effective trim.
- R2: While `rst_n` is low, the block captures `factory_trim`. After reset, `trim_code` equals the captured value and word bits [5:0] read 0. Later changes on `factory_trim` have no effect.
- R3: A write with `wr_strb[0]` high stores `wr_data[5:0]`. From the following cycle, that value reads back in bits [5:0] and drives `trim_code`, and it keeps doing so until the next reset.
- R4: A write with `wr_strb[0]` low leaves both the trim field and `trim_code` unchanged.
- R5: Bits [20:16] hold the divide factor minus 1 and are written under `wr_strb[2]`. Bit 24 is the standby keep-alive bit, written under `wr_strb[3]`, and it drives `standby_keep`. Both fields read back and reset to 0.
- R6: Bit 31 reads the stable flag and ignores writes. Bits [15:6], [23:21] and [30:25] always read 0.
- R7: `clk_stable` rises after the 16th rising clock edge at which `osc_en` is high. It is 0 in any cycle where `osc_en` is 0.
- R8: `div_pulse` is high for exactly one cycle in every N cycles, where N is the programmed factor. After reset, N is 1 and the pulse is high in every cycle.
- R9: A new divide factor takes effect only at the next terminal count. The period in progress, including one that ends on the write's own edge, completes with the old factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, also the register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| factory_trim | input | 6 | Factory trim code, captured during reset |
| osc_en | input | 1 | Oscillator enable from the mode controller |
| wr_en | input | 1 | Write strobe for the control word |
| wr_strb | input | 4 | Byte lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| trim_code | output | 6 | Effective trim to the analog oscillator |
| standby_keep | output | 1 | Keep the oscillator on in standby |
| clk_stable | output | 1 | Oscillator provides a stable clock |
| div_pulse | output | 1 | Divided clock enable pulse |

## Verification
A write lands on one rising edge. Its effect on `rd_data`, `trim_code` and `standby_keep` is therefore checked at the falling edge that follows that rising edge. The stable flag is sampled at the falling edge after the 15th and after the 16th enabled rising edge, and again 1 ns after `osc_en` falls, because that drop is combinational. Divider periods are counted in falling edges from one sampled pulse to the next. For the factor-change case, the write is issued on the falling edge where a pulse is seen, so it lands exactly on the terminal edge. The next two periods are then expected to be the old factor and the new factor.

// File: rtl/osc_trim_pkg.sv
// Package: shared constants for the oscillator trim controller.
// Assumes a 32-bit word with byte strobes; field positions are fixed here.
package osc_trim_pkg;
    localparam int unsigned BUS_W    = 32;
    localparam int unsigned STRB_W   = BUS_W / 8;
    localparam int unsigned TRIM_LSB = 0;
    localparam int unsigned DIV_LSB  = 16;
    localparam int unsigned STBY_BIT = 24;
    localparam int unsigned STAT_BIT = 31;
    localparam int unsigned TRIM_LANE = TRIM_LSB / 8;
    localparam int unsigned DIV_LANE  = DIV_LSB / 8;
    localparam int unsigned STBY_LANE = STBY_BIT / 8;

    typedef logic [BUS_W-1:0]  bus_word_t;
    typedef logic [STRB_W-1:0] bus_strb_t;
endpackage

// File: rtl/osc_trim_store.sv
// Module: holds the software trim and the factory trim captured in reset.
// Assumes factory_trim is valid while rst_n is low. The written flag selects
// which value is effective; the readable field stays zero until written.
module osc_trim_store #(
    parameter int unsigned TRIM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIM_W-1:0] factory_trim,
    input  logic              trim_we,
    input  logic [TRIM_W-1:0] trim_wdata,
    output logic [TRIM_W-1:0] trim_field,
    output logic [TRIM_W-1:0] trim_eff
);
    logic [TRIM_W-1:0] factory_q;
    logic [TRIM_W-1:0] user_q;
    logic              written_q;

    // Capture factory trim in reset; accept software trim afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            factory_q <= factory_trim;
            user_q    <= '0;
            written_q <= 1'b0;
        end else if (trim_we) begin
            user_q    <= trim_wdata;
            written_q <= 1'b1;
        end
    end

    // Select the trim that reaches the oscillator.
    always_comb begin
        trim_field = user_q;
        trim_eff   = written_q ? user_q : factory_q;
    end
endmodule

// File: rtl/osc_stable_timer.sv
// Module: raises the stable flag a fixed number of enabled cycles after the
// enable rises; drops it combinationally when the enable is low.
// Assumes the counter saturates and so needs no wrap handling.
module osc_stable_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic stable
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Count enabled cycles up to the limit; clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag is valid only while the enable is still high.
    always_comb stable = en && (cnt_q == LIMIT);
endmodule

// File: rtl/osc_div_gen.sv
// Module: produces a one-cycle enable every (div_sel + 1) clock cycles.
// Assumes div_sel may change at any time; it is adopted at terminal count.
module osc_div_gen #(
    parameter int unsigned DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             pulse
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] act_q;
    logic             term;

    // Terminal count marks the last cycle of the period in progress.
    always_comb term = (cnt_q == act_q);

    // Advance the counter; reload the active factor only at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (term) begin
            cnt_q <= '0;
            act_q <= div_sel;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The pulse is the terminal cycle itself.
    always_comb pulse = term;
endmodule

// File: rtl/osc_trim_ctrl.sv
// Module: top of the oscillator trim and divide controller. Decodes the byte
// strobed control word, holds divide and standby fields, assembles the
// read word and instantiates trim storage, stable timer and divider.
// Assumes bus and oscillator share clk; reads are combinational.
module osc_trim_ctrl
    import osc_trim_pkg::*;
#(
    parameter int unsigned TRIM_W        = 6,
    parameter int unsigned DIV_W         = 5,
    parameter int unsigned STABLE_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TRIM_W-1:0]   factory_trim,
    input  logic                osc_en,
    input  logic                wr_en,
    input  logic [STRB_W-1:0]   wr_strb,
    input  logic [BUS_W-1:0]    wr_data,
    output logic [BUS_W-1:0]    rd_data,
    output logic [TRIM_W-1:0]   trim_code,
    output logic                standby_keep,
    output logic                clk_stable,
    output logic                div_pulse
);
    logic [TRIM_W-1:0] trim_field;
    logic [DIV_W-1:0]  div_q;
    logic              stby_q;
    logic              trim_we;
    logic              unused_wr;

    always_comb trim_we   = wr_en && wr_strb[TRIM_LANE];
    always_comb unused_wr = ^{wr_data, wr_strb};

    // Divide and standby fields, each under its own byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            stby_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_strb[DIV_LANE])  div_q  <= wr_data[DIV_LSB +: DIV_W];
            if (wr_strb[STBY_LANE]) stby_q <= wr_data[STBY_BIT];
        end
    end

    osc_trim_store #(.TRIM_W(TRIM_W)) i_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .factory_trim (factory_trim),
        .trim_we      (trim_we),
        .trim_wdata   (wr_data[TRIM_LSB +: TRIM_W]),
        .trim_field   (trim_field),
        .trim_eff     (trim_code)
    );

    osc_stable_timer #(.CYCLES(STABLE_CYCLES)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (osc_en),
        .stable (clk_stable)
    );

    osc_div_gen #(.DIV_W(DIV_W)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_q),
        .pulse   (div_pulse)
    );

    // Assemble the read word; unassigned bits read zero.
    always_comb begin
        rd_data                      = '0;
        rd_data[TRIM_LSB +: TRIM_W]  = trim_field;
        rd_data[DIV_LSB +: DIV_W]    = div_q;
        rd_data[STBY_BIT]            = stby_q;
        rd_data[STAT_BIT]            = clk_stable;
    end

    // Standby output follows its field.
    always_comb standby_keep = stby_q;
endmodule

// File: rtl/osc_trim_ctrl_chk.sv
// Module: assertion checker bound to osc_trim_ctrl.
// Assumes the default field layout from osc_trim_pkg.
module osc_trim_ctrl_chk
    import osc_trim_pkg::*;
#(
    parameter int unsigned TRIM_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_en,
    input logic              wr_en,
    input logic [STRB_W-1:0] wr_strb,
    input logic [BUS_W-1:0]  wr_data,
    input logic [BUS_W-1:0]  rd_data,
    input logic [TRIM_W-1:0] trim_code,
    input logic              standby_keep,
    input logic              clk_stable,
    input logic              div_pulse
);
    a_r3_trim_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb[0]) |=> (trim_code == $past(wr_data[TRIM_W-1:0]))
                                  && (rd_data[TRIM_W-1:0] == $past(wr_data[TRIM_W-1:0])));

    a_r4_trim_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_strb[0]) |=> $stable(trim_code) && $stable(rd_data[TRIM_W-1:0]));

    a_r5_standby_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb[3]) |=> (standby_keep == $past(wr_data[STBY_BIT])));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15:6] == '0) && (rd_data[23:21] == '0) && (rd_data[30:25] == '0));

    a_r6_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[STAT_BIT] == clk_stable);

    a_r7_drop_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !clk_stable);

    a_r7_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stable) |-> $past(osc_en));

    a_r8_pulse_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(div_pulse));
endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(.TRIM_W(TRIM_W)) i_chk (.*);

// File: tb/test_osc_trim_ctrl.sv
`timescale 1ns/1ps
module test_osc_trim_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  factory_trim = 6'h2B;
    logic        osc_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [5:0]  trim_code;
    logic        standby_keep, clk_stable, div_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [5:0] m_trim, m_fact;
    logic       m_written;
    logic [4:0] m_div;
    logic       m_stby;

    always #2.5 clk = ~clk;

    osc_trim_ctrl i_osc_trim_ctrl (
        .clk(clk), .rst_n(rst_n), .factory_trim(factory_trim), .osc_en(osc_en),
        .wr_en(wr_en), .wr_strb(wr_strb), .wr_data(wr_data), .rd_data(rd_data),
        .trim_code(trim_code), .standby_keep(standby_keep),
        .clk_stable(clk_stable), .div_pulse(div_pulse)
    );

    function automatic logic [31:0] exp_word(input logic stat);
        logic [31:0] w = '0;
        w[5:0]   = m_trim;
        w[20:16] = m_div;
        w[24]    = m_stby;
        w[31]    = stat;
        return w;
    endfunction

    function automatic logic [5:0] exp_trim();
        return m_written ? m_trim : m_fact;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [5:0] fact);
        factory_trim = fact;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_fact = fact; m_trim = '0; m_written = 1'b0; m_div = '0; m_stby = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_strb = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
        if (s[0]) begin m_trim = d[5:0]; m_written = 1'b1; end
        if (s[2]) m_div = d[20:16];
        if (s[3]) m_stby = d[24];
    endtask

    task automatic wait_pulse();
        int n = 0;
        while (!div_pulse && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic period(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!div_pulse && n < 100);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240517));
        @(negedge clk);
        do_reset(6'h2B);

        // R2: reset state, factory trim hidden but effective
        chk("R2 reset word", rd_data, 32'h0);
        chk("R2 factory trim out", {26'd0, trim_code}, {26'd0, 6'h2B});
        chk("R8 reset pulse every cycle", {31'd0, div_pulse}, 32'd1);
        @(negedge clk);
        chk("R8 reset pulse next cycle", {31'd0, div_pulse}, 32'd1);
        factory_trim = 6'h05;
        repeat (2) @(negedge clk);
        chk("R2 factory input ignored after reset", {26'd0, trim_code}, {26'd0, 6'h2B});

        // R4: upper half write keeps factory trim
        wr(4'b1100, 32'h0103_003F);
        chk("R4 trim kept on upper write", {26'd0, trim_code}, {26'd0, 6'h2B});
        chk("R5 upper fields readable", rd_data, exp_word(1'b0));
        chk("R5 standby out", {31'd0, standby_keep}, 32'd1);
        wr(4'b0010, 32'hFFFF_FFFF);
        chk("R4 lane1 write keeps trim", {26'd0, trim_code}, {26'd0, 6'h2B});

        // R6: status bit ignores writes
        wr(4'b1000, 32'h8000_0000);
        chk("R6 status write ignored", rd_data, exp_word(1'b0));

        // R3 / R1: trim write, negative code
        wr(4'b0001, 32'h0000_0020);
        chk("R3 trim readable", rd_data, exp_word(1'b0));
        chk("R1 trim out -32", {26'd0, trim_code}, {26'd0, 6'h20});
        wr(4'b0001, 32'h0000_001F);
        chk("R1 trim out +31", {26'd0, trim_code}, {26'd0, 6'h1F});

        // R7: stable timer
        osc_en = 1'b1;
        repeat (15) @(negedge clk);
        chk("R7 not stable after 15", {31'd0, clk_stable}, 32'd0);
        @(negedge clk);
        chk("R7 stable after 16", {31'd0, clk_stable}, 32'd1);
        chk("R6 status reads 1", rd_data, exp_word(1'b1));
        wr(4'b1000, 32'h0000_0000);
        chk("R6 status unaffected by write 0", {31'd0, rd_data[31]}, 32'd1);
        osc_en = 1'b0;
        #1;
        chk("R7 drop same cycle", {31'd0, clk_stable}, 32'd0);
        @(negedge clk);

        // R8: divider periods
        foreach (n_list[i]) begin
            wr(4'b0100, {11'd0, 5'(n_list[i] - 1), 16'd0});
            wait_pulse(); period(n); wait_pulse(); period(n);
            chk("R8 period", n, n_list[i]);
        end

        // R9: change on the terminal edge, old period completes first
        wr(4'b0100, {11'd0, 5'd3, 16'd0});
        wait_pulse(); period(n); period(n);
        wr_en = 1'b1; wr_strb = 4'b0100; wr_data = {11'd0, 5'd6, 16'd0};
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0; m_div = 5'd6;
        n = 1;
        while (!div_pulse && n < 100) begin @(negedge clk); n++; end
        chk("R9 old factor completes", n, 4);
        period(n);
        chk("R9 new factor applies", n, 7);

        // R3/R4/R5/R6 random writes
        for (int k = 0; k < 200; k++) begin
            logic [3:0]  s = 4'($urandom);
            logic [31:0] d = $urandom;
            wr(s, d);
            chk("R3 R4 R5 random word", rd_data, exp_word(1'b0));
            chk("R1 random trim out", {26'd0, trim_code}, {26'd0, exp_trim()});
            chk("R5 random standby", {31'd0, standby_keep}, {31'd0, m_stby});
        end

        // R2: second reset restores hidden factory trim
        do_reset(6'h11);
        chk("R2 second reset word", rd_data, 32'h0);
        chk("R2 second factory trim", {26'd0, trim_code}, {26'd0, 6'h11});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int n_list [5] = '{1, 2, 5, 17, 32};
endmodule